// File: doc/BRIEF.md
# Half-Warp Memory Transaction Coalescer

The block accepts one memory access from a group of sixteen lanes and turns it into the smallest set of aligned memory transactions that serves every participating lane. Each lane contributes an enable bit and a byte address. One shared access width applies to the whole group, because a single instruction uses one data type. The block issues the transactions one at a time and then reports that the group is finished.

Each pass takes the lowest-numbered lane that is still unserved as the leader. The access width picks a segment size, and the pass finds the segment of that size that holds the leader's address. Every other unserved lane whose address falls in the same segment joins the pass. The pass then halves the transaction while all joined addresses still sit in one half of it, and offers the result on the transaction port. When that transaction is accepted, its lanes count as served.

The controller has three states:
- IDLE accepts a group. It moves to ISSUE when at least one lane is enabled, and to FINISH when none is.
- ISSUE offers transactions. It stays in ISSUE after each accept that leaves lanes unserved, and moves to FINISH after the accept that serves the last lane.
- FINISH raises done for one cycle and always returns to IDLE.

Top module: `hw_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1 and both `txn_valid` and `done` are 0.
- R2: The starting segment size follows `req_size`. The value of `req_size` is the log2 of the access width in bytes: 0 means 1 byte, 1 means 2 bytes, 2 to 4 mean 4, 8 or 16 bytes. Width 1 gives a 32-byte segment, width 2 gives 64 bytes, and every wider access gives 128 bytes. `txn_size` reports the size of the transaction: 0 means 32 bytes, 1 means 64 bytes, 2 means 128 bytes.
- R3: Each transaction is led by the lowest-numbered lane that is enabled and not yet served. Its `txn_base` is aligned to its own size.
- R4: Every unserved enabled lane whose address lies in the leader's starting segment is served by the same transaction. `txn_mask` bit i stands for lane i.
- R5: If all addresses in a 128-byte transaction lie in one 64-byte half, the transaction shrinks to 64 bytes. If they then lie in one 32-byte half, it shrinks again to 32 bytes. A transaction is never smaller than 32 bytes.
- R6: Each lane is served by exactly one transaction, and the masks together equal the enabled set. `done` is high for exactly one cycle, and that cycle directly follows the cycle in which the last transaction is accepted.
- R7: A group with no enabled lane issues no transaction. `done` is high in the cycle after the group is accepted.
- R8: While `txn_valid` is high and `txn_ready` is low, the offered transaction stays valid and its base, size and mask do not change.
- R9: `req_ready` is low from the cycle after a group is accepted up to and including the `done` cycle, and is high again in the next cycle. Request inputs that change during that time have no effect on the transactions.
- R10: A lane whose enable bit is 0 never appears in any mask, wherever its address points.
- R11: `req_addr` packs lane i's address in bits [i*32 +: 32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A lane group is offered |
| req_ready | output | 1 | The block can take a group |
| req_active | input | 16 | Lane enable bits |
| req_addr | input | 512 | Lane byte addresses, 32 bits per lane |
| req_size | input | 3 | Access width of the group as a log2 byte count |
| txn_valid | output | 1 | A transaction is offered |
| txn_ready | input | 1 | The memory side takes the transaction |
| txn_base | output | 32 | Transaction base address, aligned to its size |
| txn_size | output | 2 | Transaction size code (0 = 32 B, 1 = 64 B, 2 = 128 B) |
| txn_mask | output | 16 | Lanes served by this transaction |
| done | output | 1 | One-cycle pulse: the group is fully served |

## Verification
Two events can coincide:
- accepting the last transaction, which clears the final pending lanes, and
- a new group that is offered at the request port while the block is still busy.

The bench provokes this overlap by holding `req_valid` high through the whole run. It also replaces the address, enable and size inputs with unrelated values right after the real group is taken. The check is that the transactions and the count still match the original group, and that `req_ready` stays low until after the single `done` cycle. Stalled transaction handshakes are mixed in, so that the last accept and the clearing of the pending set land on cycles other than the first offer.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_FINISH = 2'd2
    } coal_state_e;

    localparam logic [1:0] SZ32  = 2'd0;
    localparam logic [1:0] SZ64  = 2'd1;
    localparam logic [1:0] SZ128 = 2'd2;

    localparam int unsigned MIN_SEG_LG2 = 5;

endpackage

// File: rtl/coal_leader.sv
module coal_leader #(
    parameter int LANES = 16,
    localparam int IW = $clog2(LANES)
) (
    input  logic [LANES-1:0] pending,
    output logic             found,
    output logic [IW-1:0]    idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/coal_gather.sv
module coal_gather #(
    parameter int LANES = 16,
    parameter int AW    = 32
) (
    input  logic [LANES*AW-1:0] addrs,
    input  logic [LANES-1:0]    pending,
    input  logic [AW-1:0]       lead_addr,
    input  logic [1:0]          seg_code,
    output logic [LANES-1:0]    hit,
    output logic                split_hi,
    output logic                split_lo
);
    import coal_pkg::*;

    logic [2:0]       seg_lg2;
    logic [LANES-1:0] d6;
    logic [LANES-1:0] d5;

    assign seg_lg2 = 3'(MIN_SEG_LG2) + {1'b0, seg_code};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [AW-1:0] a;
        assign a     = addrs[g*AW +: AW];
        assign hit[g] = pending[g] && ((a >> seg_lg2) == (lead_addr >> seg_lg2));
        assign d6[g]  = hit[g] && (a[6] != lead_addr[6]);
        assign d5[g]  = hit[g] && (a[5] != lead_addr[5]);
    end

    assign split_hi = |d6;
    assign split_lo = |d5;
endmodule

// File: rtl/coal_shrink.sv
module coal_shrink #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] lead_addr,
    input  logic [1:0]    seg_code,
    input  logic          split_hi,
    input  logic          split_lo,
    output logic [AW-1:0] base,
    output logic [1:0]    size_code
);
    import coal_pkg::*;

    always_comb begin
        unique case (seg_code)
            SZ128:   size_code = split_hi ? SZ128 : (split_lo ? SZ64 : SZ32);
            SZ64:    size_code = split_lo ? SZ64 : SZ32;
            default: size_code = SZ32;
        endcase
        base = lead_addr & ~((AW'(32) << size_code) - AW'(1));
    end
endmodule

// File: rtl/hw_coalescer.sv
module hw_coalescer #(
    parameter int LANES = 16,
    parameter int AW    = 32,
    localparam int IW   = $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [LANES-1:0]    req_active,
    input  logic [LANES*AW-1:0] req_addr,
    input  logic [2:0]          req_size,
    output logic                txn_valid,
    input  logic                txn_ready,
    output logic [AW-1:0]       txn_base,
    output logic [1:0]          txn_size,
    output logic [LANES-1:0]    txn_mask,
    output logic                done
);
    import coal_pkg::*;

    coal_state_e         state_q, state_d;
    logic [LANES*AW-1:0] addr_q;
    logic [LANES-1:0]    pend_q;
    logic [1:0]          seg_q;

    logic                found;
    logic [IW-1:0]       lead_idx;
    logic [AW-1:0]       lead_addr;
    logic [LANES-1:0]    hit;
    logic                split_hi, split_lo;
    logic [1:0]          seg_in;
    logic                accept_req, accept_txn;

    coal_leader #(.LANES(LANES)) u_leader (
        .pending (pend_q),
        .found   (found),
        .idx     (lead_idx)
    );

    assign lead_addr = addr_q[lead_idx*AW +: AW];

    coal_gather #(.LANES(LANES), .AW(AW)) u_gather (
        .addrs     (addr_q),
        .pending   (pend_q),
        .lead_addr (lead_addr),
        .seg_code  (seg_q),
        .hit       (hit),
        .split_hi  (split_hi),
        .split_lo  (split_lo)
    );

    coal_shrink #(.AW(AW)) u_shrink (
        .lead_addr (lead_addr),
        .seg_code  (seg_q),
        .split_hi  (split_hi),
        .split_lo  (split_lo),
        .base      (txn_base),
        .size_code (txn_size)
    );

    always_comb begin
        unique case (req_size)
            3'd0:    seg_in = SZ32;
            3'd1:    seg_in = SZ64;
            default: seg_in = SZ128;
        endcase
    end

    assign accept_req = req_valid && req_ready;
    assign accept_txn = txn_valid && txn_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept_req) state_d = (|req_active) ? ST_ISSUE : ST_FINISH;
            ST_ISSUE:  if (accept_txn && ((pend_q & ~hit) == '0)) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            addr_q  <= '0;
            seg_q   <= SZ32;
        end else begin
            state_q <= state_d;
            if (accept_req) begin
                pend_q <= req_active;
                addr_q <= req_addr;
                seg_q  <= seg_in;
            end else if (accept_txn) begin
                pend_q <= pend_q & ~hit;
            end
        end
    end

    always_comb begin
        req_ready = 1'b0;
        txn_valid = 1'b0;
        done      = 1'b0;
        txn_mask  = '0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_ISSUE: begin
                txn_valid = found;
                txn_mask  = hit;
            end
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
    parameter int LANES = 16,
    parameter int AW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             txn_valid,
    input logic             txn_ready,
    input logic [AW-1:0]    txn_base,
    input logic [1:0]       txn_size,
    input logic [LANES-1:0] txn_mask,
    input logic             done
);
    AST_TXN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) && $stable(txn_size) && $stable(txn_mask))); // R8
    AST_BASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_base & ((AW'(32) << txn_size) - AW'(1))) == '0)); // R3
    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_size != 2'd3)); // R2
    AST_MASK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_mask != '0)); // R4
    AST_BUSY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid || done) |-> !req_ready); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready)); // R6
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !txn_valid); // R7
endmodule

bind hw_coalescer coal_checker #(.LANES(LANES), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .txn_valid (txn_valid),
    .txn_ready (txn_ready),
    .txn_base  (txn_base),
    .txn_size  (txn_size),
    .txn_mask  (txn_mask),
    .done      (done)
);

// File: tb/tb_hw_coalescer.sv
module tb_hw_coalescer;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 16;
    localparam int AW    = 32;

    typedef struct packed {
        logic [15:0] active;
        logic [31:0] start;
        logic [31:0] stride;
        logic [2:0]  size;
        logic        stall;
        logic [4:0]  cnt;
        logic [31:0] fbase;
        logic [1:0]  fsz;
        logic [15:0] fmask;
        logic [15:0] lmask;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VT [NV] = '{
        '{16'hFFFF, 32'h1000, 32'h4,        3'd2, 1'b0, 5'd1,  32'h1000, 2'd1, 16'hFFFF, 16'hFFFF},
        '{16'hFFFF, 32'h2000, 32'h8,        3'd2, 1'b1, 5'd1,  32'h2000, 2'd2, 16'hFFFF, 16'hFFFF},
        '{16'hFFFF, 32'h3005, 32'h1,        3'd0, 1'b0, 5'd1,  32'h3000, 2'd0, 16'hFFFF, 16'hFFFF},
        '{16'hFFFF, 32'h4030, 32'h2,        3'd1, 1'b1, 5'd2,  32'h4020, 2'd0, 16'h00FF, 16'hFF00},
        '{16'hFFFF, 32'h0,    32'h80,       3'd2, 1'b0, 5'd16, 32'h0,    2'd0, 16'h0001, 16'h8000},
        '{16'h00F0, 32'h5000, 32'h4,        3'd2, 1'b0, 5'd1,  32'h5000, 2'd0, 16'h00F0, 16'h00F0},
        '{16'h8001, 32'h6040, 32'h8,        3'd3, 1'b1, 5'd2,  32'h6040, 2'd0, 16'h0001, 16'h8000},
        '{16'hFFFF, 32'h7000, 32'h10,       3'd4, 1'b0, 5'd2,  32'h7000, 2'd2, 16'h00FF, 16'hFF00},
        '{16'h0000, 32'hA000, 32'h4,        3'd2, 1'b0, 5'd0,  32'h0,    2'd0, 16'h0000, 16'h0000},
        '{16'hFFFF, 32'h803C, 32'hFFFFFFFC, 3'd2, 1'b0, 5'd1,  32'h8000, 2'd1, 16'hFFFF, 16'hFFFF},
        '{16'hFFFF, 32'h9060, 32'hFFFFFFF8, 3'd2, 1'b1, 5'd2,  32'h9000, 2'd2, 16'h1FFF, 16'hE000}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic [LANES-1:0]    req_active = '0;
    logic [LANES*AW-1:0] req_addr = '0;
    logic [2:0]          req_size = '0;
    logic                txn_valid;
    logic                txn_ready = 1'b0;
    logic [AW-1:0]       txn_base;
    logic [1:0]          txn_size;
    logic [LANES-1:0]    txn_mask;
    logic                done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hw_coalescer dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_active(req_active), .req_addr(req_addr), .req_size(req_size),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_base(txn_base),
        .txn_size(txn_size), .txn_mask(txn_mask), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int low_bit(input logic [15:0] m);
        for (int i = 15; i >= 0; i--) if (m[i]) low_bit = i;
        if (m == 0) low_bit = 16;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic drive_group(input vec_t v);
        req_active = v.active;
        req_size   = v.size;
        for (int l = 0; l < LANES; l++) req_addr[l*AW +: AW] = v.start + v.stride * l;
    endtask

    task automatic run_vec(input vec_t v, input int id);
        int n = 0;
        int gap = 0;
        bit held = 0;
        bit tog = 0;
        bit got_done = 0;
        logic [15:0] uni = '0;
        logic [15:0] lastm = '0;
        logic [31:0] sb = '0;
        logic [1:0]  ss = '0;
        logic [15:0] sm = '0;
        @(negedge clk);
        drive_group(v);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_active = ~v.active;
        req_addr   = {LANES{32'hDEAD_BEE0}};
        req_size   = 3'd0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            gap++;
            check(!req_ready, "R9 ready low while busy", req_ready, 0);
            if (done) begin got_done = 1; break; end
            if (txn_valid) begin
                if (held) check(txn_base == sb && txn_size == ss && txn_mask == sm,
                                "R8 held transaction", {txn_base, txn_mask}, {sb, sm});
                tog = ~tog;
                txn_ready = v.stall ? tog : 1'b1;
                if (txn_ready) begin
                    check(low_bit(txn_mask) == low_bit(v.active & ~uni), "R3 leader lowest pending",
                          low_bit(txn_mask), low_bit(v.active & ~uni));
                    check((txn_mask & uni) == 0 && (txn_mask & ~v.active) == 0,
                          "R10 mask within unserved enabled lanes", txn_mask, v.active & ~uni);
                    if (n == 0) check(txn_base == v.fbase && txn_size == v.fsz && txn_mask == v.fmask,
                                      "R2 R4 R5 first transaction", {txn_base, 14'd0, txn_size, txn_mask},
                                      {v.fbase, 14'd0, v.fsz, v.fmask});
                    uni |= txn_mask;
                    lastm = txn_mask;
                    n++;
                    gap = 0;
                end
                held = !txn_ready;
                sb = txn_base; ss = txn_size; sm = txn_mask;
            end else begin
                txn_ready = 1'b0;
            end
        end
        txn_ready = 1'b0;
        req_valid = 1'b0;
        check(got_done && gap == 1, v.cnt == 0 ? "R7 done right after empty group" : "R6 done after last accept",
              gap, 1);
        check(n == v.cnt, "R6 transaction count", n, v.cnt);
        check(uni == v.active, "R6 lanes covered", uni, v.active);
        if (v.cnt != 0) check(lastm == v.lmask, "R4 last mask", lastm, v.lmask);
        @(negedge clk);
        check(req_ready && !done, "R9 ready after done", {req_ready, done}, 2'b10);
        if (id < 0) $display("vector %0d", id);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready && !txn_valid && !done, "R1 reset state", {req_ready, txn_valid, done}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !txn_valid && !done, "R1 idle after reset", {req_ready, txn_valid, done}, 3'b100);

        for (int i = 0; i < NV; i++) run_vec(VT[i], i);

        // R1: reset in the middle of a group drops it
        @(negedge clk);
        drive_group(VT[4]);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        txn_ready = 1'b1;
        repeat (2) @(negedge clk);
        check(txn_valid, "R6 group in progress", txn_valid, 1);
        txn_ready = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(req_ready && !txn_valid && !done, "R1 reset mid group", {req_ready, txn_valid, done}, 3'b100);
        run_vec(VT[3], 3);

        // R11: lane 15 alone sits in the top slot of req_addr
        @(negedge clk);
        req_active = 16'h8000;
        req_size   = 3'd2;
        req_addr   = '0;
        req_addr[15*AW +: AW] = 32'h0000_C0E4;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        check(txn_valid && txn_mask == 16'h8000 && txn_base == 32'hC0E0 && txn_size == 2'd0,
              "R11 lane 15 address slot", {txn_base, txn_mask}, {32'hC0E0, 16'h8000});
        txn_ready = 1'b1;
        @(negedge clk);
        txn_ready = 1'b0;
        check(done, "R6 single-lane done", done, 1);
        @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule